// File: doc/BRIEF.md
# PWM Timer Tick Prescaler

This block makes the per-channel count enables for a five-channel PWM timer. Two 8-bit prescalers divide the core clock. Channels 0 and 1 take their tick from the first prescaler, and channels 2, 3 and 4 take it from the second. Each channel has a 4-bit selection code. The code either picks a power-of-two divider after its prescaler or picks an external tick input. Every output is a single-cycle enable, and the downstream counting channels advance on it.

Software writes two configuration words over a plain write port. The prescaler word holds both reload values. The selection word holds the five channel codes. Any write restarts both prescalers and both divider chains from zero. As a result, the first tick after a write comes one full new period later. A parameter sets the divider base. With the default base of 1, code n divides by 2^(n+1), with a cap at 16. Code 4 selects the external tick. The two external tick inputs are asynchronous. Each one passes through a synchroniser and a rising-edge detector.

Top module: `pwm_tick_gen`

## Requirements
- R1: While rstN is low every tickEn bit is 0. After reset both prescaler values and all selection codes are 0, so each channel ticks once every 2 cycles, and the first tick comes in the second cycle after reset is released.
- R2: In the prescaler word (wrSel=0), bits [7:0] are the reload for channels 0 and 1, and bits [15:8] are the reload for channels 2, 3 and 4. Two channels of the same group that have the same code tick in the same cycles.
- R3: For a divider code c with c+1 <= 4, a channel ticks every (p+1)*2^(c+1) cycles, where p is the reload of its group.
- R4: A non-external code whose exponent c+1 exceeds 4 (codes 5 to 15) divides by 16, so the period is (p+1)*16.
- R5: In the selection word (wrSel=1), channel k takes its code from bits [4k+3:4k].
- R6: Code 4 routes the external tick to the channel. extTickA serves channels 0 and 1, and extTickB serves channels 2, 3 and 4. Each rising edge gives exactly one tick, and a channel whose external input is idle does not tick.
- R7: External inputs have no effect on a channel that is set to a divider code.
- R8: A write to either word restarts all counters. The first tick on a divider channel then appears in cycle index P-1 after the write edge (index 0 is the cycle right after it), and later ticks follow every P cycles.
- R9: Every tick lasts one cycle. A tick is never high in two consecutive cycles unless a write falls between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Configuration write strobe |
| wrSel | input | 1 | 0 selects the prescaler word, 1 selects the selection word |
| wrData | input | 32 | Write data |
| extTickA | input | 1 | Asynchronous external tick for channels 0 and 1 |
| extTickB | input | 1 | Asynchronous external tick for channels 2 to 4 |
| tickEn | output | 5 | One-cycle tick enable per channel |

## Verification
The bench sweeps every code in each channel position against four pairs of prescaler reloads. In each pass the five fields hold different codes, so a misplaced field or a wrong group mapping shows up as a wrong period on one channel. Each pass measures both the first tick after the write and the interval after it, which separates a restart error from a rate error. Codes 5 to 15 show whether the divider is capped. Separate runs check the following:
- toggling the external inputs while the channels are on divider codes;
- sending a known number of external edges of different counts to the two groups;
- rewriting the prescaler word partway through a long period.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  // strobes from the register decode to the counting datapath
  typedef struct packed {
    logic clrPre;  // restart prescaler counters
    logic clrDiv;  // restart divider chains
  } cfgStb_t;
endpackage

// File: rtl/pwm_tick_ctrl.sv
module pwm_tick_ctrl
  import pwm_tick_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PRE_W   = 8,
  parameter int MUX_TOT = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic                   wrSel,
  input  logic [DATA_W-1:0]      wrData,
  output logic [1:0][PRE_W-1:0]  preVal,
  output logic [MUX_TOT-1:0]     muxVal,
  output cfgStb_t                stb
);
  localparam int USED_W = (2 * PRE_W > MUX_TOT) ? 2 * PRE_W : MUX_TOT;

  logic unusedData;
  generate
    if (DATA_W > USED_W) begin : g_spare
      assign unusedData = ^wrData[DATA_W-1:USED_W];
    end else begin : g_nospare
      assign unusedData = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preVal <= '0;
      muxVal <= '0;
    end else if (wrEn) begin
      if (!wrSel) begin
        preVal[0] <= wrData[PRE_W-1:0];
        preVal[1] <= wrData[2*PRE_W-1:PRE_W];
      end else begin
        muxVal <= wrData[MUX_TOT-1:0];
      end
    end
  end

  // any write restarts the whole tick generator
  always_comb begin
    stb.clrPre = wrEn;
    stb.clrDiv = wrEn;
  end
endmodule

// File: rtl/pwm_tick_dp.sv
module pwm_tick_dp
  import pwm_tick_pkg::*;
#(
  parameter int          NUM_CH        = 5,
  parameter int          GRP0_CH       = 2,
  parameter int          PRE_W         = 8,
  parameter int          MUX_W         = 4,
  parameter int          DIV_BASE      = 1,
  parameter int          MAX_LOG2      = 4,
  parameter logic [15:0] EXT_CODE_MASK = 16'h0010
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cfgStb_t                   stb,
  input  logic [1:0][PRE_W-1:0]     preVal,
  input  logic [NUM_CH*MUX_W-1:0]   muxVal,
  input  logic [1:0]                extIn,
  output logic [NUM_CH-1:0]         tickEn
);
  localparam int DCW = MAX_LOG2;

  logic [1:0][PRE_W-1:0] preCnt;
  logic [1:0][DCW-1:0]   divCnt;
  logic [1:0]            preHit;
  logic [1:0][2:0]       extSync;
  logic [1:0]            extPulse;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_grp
      assign preHit[g]   = (preCnt[g] == preVal[g]);
      assign extPulse[g] = extSync[g][1] & ~extSync[g][2];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          preCnt[g] <= '0;
        end else if (stb.clrPre || preHit[g]) begin
          preCnt[g] <= '0;
        end else begin
          preCnt[g] <= preCnt[g] + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          divCnt[g] <= '0;
        end else if (stb.clrDiv) begin
          divCnt[g] <= '0;
        end else if (preHit[g]) begin
          divCnt[g] <= divCnt[g] + 1'b1;
        end
      end

      // two-flop synchroniser plus one history flop for the edge detect
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          extSync[g] <= '0;
        end else begin
          extSync[g] <= {extSync[g][1:0], extIn[g]};
        end
      end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam int GRP = (i < GRP0_CH) ? 0 : 1;
      logic [MUX_W-1:0] code;
      logic [DCW-1:0]   mask;
      logic             isExt;

      assign code  = muxVal[i*MUX_W +: MUX_W];
      assign isExt = EXT_CODE_MASK[code];

      always_comb begin
        int expo;
        expo = int'(code) + DIV_BASE;
        if (expo > MAX_LOG2) expo = MAX_LOG2;
        mask = DCW'((1 << expo) - 1);
      end

      assign tickEn[i] = isExt ? extPulse[GRP]
                               : (preHit[GRP] && ((divCnt[GRP] & mask) == mask));
    end
  endgenerate
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_tick_pkg::*;
#(
  parameter int          NUM_CH        = 5,
  parameter int          GRP0_CH       = 2,
  parameter int          DATA_W        = 32,
  parameter int          PRE_W         = 8,
  parameter int          MUX_W         = 4,
  parameter int          DIV_BASE      = 1,
  parameter int          MAX_LOG2      = 4,
  parameter logic [15:0] EXT_CODE_MASK = 16'h0010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              extTickA,
  input  logic              extTickB,
  output logic [NUM_CH-1:0] tickEn
);
  localparam int MUX_TOT = NUM_CH * MUX_W;

  cfgStb_t               stb;
  logic [1:0][PRE_W-1:0] preVal;
  logic [MUX_TOT-1:0]    muxVal;

  pwm_tick_ctrl #(
    .DATA_W (DATA_W),
    .PRE_W  (PRE_W),
    .MUX_TOT(MUX_TOT)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrSel (wrSel),
    .wrData(wrData),
    .preVal(preVal),
    .muxVal(muxVal),
    .stb   (stb)
  );

  pwm_tick_dp #(
    .NUM_CH       (NUM_CH),
    .GRP0_CH      (GRP0_CH),
    .PRE_W        (PRE_W),
    .MUX_W        (MUX_W),
    .DIV_BASE     (DIV_BASE),
    .MAX_LOG2     (MAX_LOG2),
    .EXT_CODE_MASK(EXT_CODE_MASK)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .preVal(preVal),
    .muxVal(muxVal),
    .extIn ({extTickB, extTickA}),
    .tickEn(tickEn)
  );
endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk #(
  parameter int          NUM_CH        = 5,
  parameter int          GRP0_CH       = 2,
  parameter int          MUX_W         = 4,
  parameter int          DIV_BASE      = 1,
  parameter logic [15:0] EXT_CODE_MASK = 16'h0010
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic [NUM_CH-1:0]       tickEn,
  input logic [NUM_CH*MUX_W-1:0] muxVal
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |-> tickEn == '0);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      logic extSel;
      assign extSel = EXT_CODE_MASK[muxVal[i*MUX_W +: MUX_W]];

      if (DIV_BASE > 0) begin : g_div
        // R9
        single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
          (tickEn[i] && !wrEn) |=> !tickEn[i]);
        // R8
        restart_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
          wrEn |=> (!tickEn[i] || extSel));
      end

      if (i != 0 && i != GRP0_CH) begin : g_pair
        localparam int REF = (i < GRP0_CH) ? 0 : GRP0_CH;
        // R2
        shared_group_chk: assert property (@(posedge clk) disable iff (!rstN)
          (muxVal[i*MUX_W +: MUX_W] == muxVal[REF*MUX_W +: MUX_W])
            |-> (tickEn[i] == tickEn[REF]));
      end
    end
  endgenerate
endmodule

bind pwm_tick_gen pwm_tick_gen_chk #(
  .NUM_CH       (NUM_CH),
  .GRP0_CH      (GRP0_CH),
  .MUX_W        (MUX_W),
  .DIV_BASE     (DIV_BASE),
  .EXT_CODE_MASK(EXT_CODE_MASK)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .wrEn  (wrEn),
  .tickEn(tickEn),
  .muxVal(muxVal)
);

// File: tb/pwm_tick_gen_bench.sv
`timescale 1ns/1ps
module pwm_tick_gen_bench;
  localparam int NCH  = 5;
  localparam int BASE = 1;
  localparam int MAXL = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        extDrvA = 1'b0, extDrvB = 1'b0;
  logic        noiseA = 1'b0, noiseB = 1'b0;
  logic        extRun = 1'b0;
  logic        extTickA, extTickB;
  logic [NCH-1:0] tickEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign extTickA = extRun ? noiseA : extDrvA;
  assign extTickB = extRun ? noiseB : extDrvB;

  always #5 clk = ~clk;
  always #43 noiseA = ~noiseA;
  always #61 noiseB = ~noiseB;

  pwm_tick_gen u_pwm_tick_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .extTickA(extTickA), .extTickB(extTickB), .tickEn(tickEn)
  );

  task automatic cfgWrite(input logic sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Called at the negedge right after a write edge or reset release (index 0).
  task automatic checkPeriods(input int pre0, input int pre1,
                              input logic [19:0] mux, input string forceTag);
    int expP[NCH];
    bit ext[NCH];
    int first[NCH];
    int second[NCH];
    int maxP = 1;
    for (int c = 0; c < NCH; c++) begin
      int code = int'(mux[c*4 +: 4]);
      int e = code + BASE;
      int p = (c < 2) ? pre0 : pre1;
      if (e > MAXL) e = MAXL;
      ext[c] = (code == 4);
      expP[c] = (p + 1) << e;
      if (!ext[c] && expP[c] > maxP) maxP = expP[c];
      first[c] = -1; second[c] = -1;
    end
    for (int idx = 0; idx < 2 * maxP + 3; idx++) begin
      for (int c = 0; c < NCH; c++) begin
        if (tickEn[c]) begin
          if (first[c] < 0) first[c] = idx;
          else if (second[c] < 0) second[c] = idx;
        end
      end
      @(negedge clk);
    end
    for (int c = 0; c < NCH; c++) begin
      string tag;
      int code = int'(mux[c*4 +: 4]);
      checks++;
      if (forceTag != "") tag = forceTag;
      else if (ext[c]) tag = "R6";
      else if (code + BASE > MAXL) tag = "R4";
      else tag = "R3";
      if (ext[c]) begin
        if (first[c] >= 0) begin
          errors++;
          $display("FAIL %s ch%0d idle external input: tick at %0d expected none",
                   tag, c, first[c]);
        end
      end else if (first[c] != expP[c] - 1 || second[c] - first[c] != expP[c]) begin
        errors++;
        $display("FAIL %s/R2/R5/R8 ch%0d code %0d pre %0d/%0d: first %0d interval %0d expected first %0d interval %0d",
                 tag, c, code, pre0, pre1, first[c], second[c] - first[c],
                 expP[c] - 1, expP[c]);
      end
    end
  endtask

  initial begin
    int p0s[4] = '{0, 1, 2, 7};
    int p1s[4] = '{3, 0, 5, 1};
    int cntA, cntB;
    logic [19:0] mux;
    // R1: quiet during reset
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (tickEn !== '0) begin
        errors++;
        $display("FAIL R1 tick during reset: %b expected 0", tickEn);
      end
    end
    @(negedge clk);
    rstN = 1'b1;
    checkPeriods(0, 0, 20'h00000, "R1");

    // R2 R3 R4 R5: sweep all codes in each field against prescaler pairs
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < NCH; c++) mux[c*4 +: 4] = 4'((b + 3 * c) % 16);
        cfgWrite(1'b0, {16'h0, 8'(p1s[p]), 8'(p0s[p])});
        cfgWrite(1'b1, {12'h0, mux});
        checkPeriods(p0s[p], p1s[p], mux, "");
      end
    end

    // R7: external activity ignored in divider mode
    cfgWrite(1'b0, {16'h0, 8'd2, 8'd1});
    extRun = 1'b1;
    cfgWrite(1'b1, {12'h0, 20'h11111});
    checkPeriods(1, 2, 20'h11111, "R7");
    extRun = 1'b0;

    // R6: counted external edges, different counts per group
    cfgWrite(1'b1, {12'h0, 20'h44444});
    cntA = 0; cntB = 0;
    for (int s = 0; s < 42; s++) begin
      extDrvA = ((s / 6) < 5) && ((s % 6) < 3);
      extDrvB = ((s / 6) < 3) && ((s % 6) < 3);
      @(negedge clk);
      if (tickEn[0]) cntA++;
      if (tickEn[3]) cntB++;
      checks++;
      if (tickEn[1] !== tickEn[0] || tickEn[2] !== tickEn[3] || tickEn[4] !== tickEn[3]) begin
        errors++;
        $display("FAIL R6 group mismatch: %b", tickEn);
      end
    end
    checks++;
    if (cntA != 5) begin
      errors++;
      $display("FAIL R6 extTickA pulses: %0d expected 5", cntA);
    end
    checks++;
    if (cntB != 3) begin
      errors++;
      $display("FAIL R6 extTickB pulses: %0d expected 3", cntB);
    end

    // R8: rewrite the prescaler word partway through a long period
    cfgWrite(1'b0, {16'h0, 8'd7, 8'd7});
    cfgWrite(1'b1, {12'h0, 20'h33333});
    repeat (50) @(negedge clk);
    cfgWrite(1'b0, {16'h0, 8'd7, 8'd7});
    checkPeriods(7, 7, 20'h33333, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule